// File: doc/BRIEF.md
# Paged write load controller

This block gathers single-byte writes from a host into a one-page staging buffer and later moves them into a byte-wide backing array. The first byte accepted while the block is idle fixes the page for the session. Further bytes for that page can arrive in any order, and a repeated offset replaces the staged value. When the host stops sending bytes for a configurable number of clock cycles, the session closes and a programming period of fixed length begins. During that period the controller reports busy, refuses new bytes, and copies only the staged offsets into the array. The other bytes of the page keep their old values.

The array itself is outside the block. The controller drives a single write port toward it and passes a host read address straight through to it. The address and data of the most recently accepted byte are exported for status logic elsewhere. A sticky flag records any byte that tried to join a session with the wrong page.

Top module: `pwl_load_ctrl`

## Requirements
- R1: The address is split so that bits 14..6 form the page number and bits 5..0 form the byte offset. A staged byte is written to the array at the session page concatenated with its own offset.
- R2: While idle, an accepted byte opens a session and latches its page. A session holds 1 to 64 bytes in any order. When an offset is loaded more than once, the last value loaded is the one committed.
- R3: Programming starts on the clock edge that completes LOAD_WINDOW consecutive cycles with no accepted byte after the last accepted byte. From then on, busy reads 1.
- R4: During a session, a byte whose page differs from the latched page is discarded. It changes neither the buffer nor the timeout count, and it sets load_err. load_err then stays 1 until reset.
- R5: Only staged offsets are written to the array. There is exactly one array write per staged offset, issued in ascending offset order in the first 64 cycles of the programming period, and only while busy is 1.
- R6: busy stays 1 for exactly WRITE_CYCLES cycles. Any write request made while busy is ignored and has no effect on the array, the buffer or the last-byte outputs.
- R7: The staged-offset record is cleared when programming ends, so the next session commits only its own bytes.
- R8: A low rst_n on a clock edge clears busy, load_err, the session, the timers and the last-byte outputs (to 0). The array contents are left untouched.
- R9: last_addr and last_data show the address and data of the most recently accepted byte.
- R10: arr_raddr follows rd_addr, and rd_data follows arr_rdata, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host byte write request, sampled on each rising edge |
| wr_addr | input | 15 | Host write address: page in 14..6, offset in 5..0 |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 15 | Host read address |
| rd_data | output | 8 | Host read data |
| busy | output | 1 | Programming period in progress |
| load_err | output | 1 | Sticky flag for a discarded byte with the wrong page |
| last_addr | output | 15 | Address of the last accepted byte |
| last_data | output | 8 | Data of the last accepted byte |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 15 | Array write address |
| arr_wdata | output | 8 | Array write data |
| arr_raddr | output | 15 | Array read address |
| arr_rdata | input | 8 | Array read data |

## Verification
The assertions check the following on every cycle:
- Array writes occur only while busy.
- Writes in consecutive cycles keep one page and rise in offset.
- Every busy period lasts exactly the write-cycle count.
- load_err never falls without a reset.
- A request made while busy leaves the last-byte outputs unchanged.

Other properties depend on history that a short property cannot hold, so only the bench's scenarios can show them. These are: which offsets get committed after reloads, whether a stale staged-offset record leaks into a later page, the exact timeout measured from the last accepted byte, the effect of a wrong-page byte on that count, and the array surviving a reset mid-session.

// File: rtl/pwl_pkg.sv
// Shared types for the paged write load controller.
package pwl_pkg;
    // Controller phase: waiting, collecting bytes, or timed programming.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } pwl_phase_e;
endpackage

// File: rtl/pwl_page_buffer.sv
// Staging storage for one page: a data slot and a loaded flag per offset.
// Assumes ld_en and clr_mask are never high together (the sequencer
// loads only outside programming and clears only at its end).
module pwl_page_buffer #(
    parameter int OFS_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [OFS_W-1:0]  ld_ofs,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              clr_mask,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SLOTS = 1 << OFS_W;

    logic [SLOTS-1:0]             mask_q;
    logic [SLOTS-1:0][DATA_W-1:0] slot_q;

    // Loaded flags: set by a load, cleared by reset or at the end of programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr_mask) begin
            mask_q <= '0;
        end else if (ld_en) begin
            mask_q[ld_ofs] <= 1'b1;
        end
    end

    // Data slots: the latest load per offset wins. Reset is not needed here.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            slot_q[ld_ofs] <= ld_data;
        end
    end

    // Read side used by the commit scan.
    assign rd_valid = mask_q[rd_ofs];
    assign rd_data  = slot_q[rd_ofs];
endmodule

// File: rtl/pwl_sequencer.sv
// Session sequencer: latches the page, times the gap between loads,
// then runs the programming period and produces the commit scan index.
// Assumes WRITE_CYCLES >= 2**OFS_W so that the scan fits in the period.
module pwl_sequencer
    import pwl_pkg::*;
#(
    parameter int PAGE_W       = 9,
    parameter int OFS_W        = 6,
    parameter int LOAD_WINDOW  = 37500,
    parameter int WRITE_CYCLES = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    output logic              accept,
    output logic              busy,
    output logic              load_err,
    output logic [PAGE_W-1:0] page_q,
    output logic              scan_act,
    output logic [OFS_W-1:0]  scan_ofs,
    output logic              clr_mask
);
    localparam int LW_W = $clog2(LOAD_WINDOW + 1);
    localparam int WC_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [LW_W-1:0] LW_LAST  = LW_W'(LOAD_WINDOW - 1);
    localparam logic [WC_W-1:0] WC_LAST  = WC_W'(WRITE_CYCLES - 1);
    localparam logic [WC_W-1:0] SCAN_END = WC_W'(1 << OFS_W);

    pwl_phase_e      phase_q;
    logic [LW_W-1:0] gap_q;
    logic [WC_W-1:0] prog_q;
    logic            page_hit;
    logic            mismatch;

    // Decide whether the current request joins the session.
    always_comb begin
        page_hit = (wr_page == page_q);
        accept   = wr_en && ((phase_q == PH_IDLE) ||
                             (phase_q == PH_LOAD && page_hit));
        mismatch = wr_en && (phase_q == PH_LOAD) && !page_hit;
    end

    // Phase, gap timer, programming timer, latched page and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            gap_q    <= '0;
            prog_q   <= '0;
            page_q   <= '0;
            load_err <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (wr_en) begin
                        phase_q <= PH_LOAD;
                        page_q  <= wr_page;
                        gap_q   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (accept) begin
                        gap_q <= '0;
                    end else if (gap_q == LW_LAST) begin
                        phase_q <= PH_PROG;
                        prog_q  <= '0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                    if (mismatch) begin
                        load_err <= 1'b1;
                    end
                end
                PH_PROG: begin
                    if (prog_q == WC_LAST) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        prog_q <= prog_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Programming outputs: busy flag, scan window and end-of-period clear.
    always_comb begin
        busy     = (phase_q == PH_PROG);
        scan_act = busy && (prog_q < SCAN_END);
        scan_ofs = prog_q[OFS_W-1:0];
        clr_mask = busy && (prog_q == WC_LAST);
    end
endmodule

// File: rtl/pwl_last_byte.sv
// Holds the address and data of the most recently accepted host byte.
module pwl_last_byte #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    // Capture on every accepted byte. Reset clears the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (take) begin
            last_addr <= in_addr;
            last_data <= in_data;
        end
    end
endmodule

// File: rtl/pwl_load_ctrl.sv
// Top of the paged write load controller. Host bytes are staged per page
// and committed to an external array after an idle gap. The array is
// assumed to write on the rising edge when arr_we is high and to return
// read data combinationally.
module pwl_load_ctrl #(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 6,
    parameter int LOAD_WINDOW  = 37500,
    parameter int WRITE_CYCLES = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              load_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [DATA_W-1:0] arr_rdata
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              accept;
    logic              scan_act;
    logic              clr_mask;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  scan_ofs;
    logic              slot_valid;
    logic [DATA_W-1:0] slot_data;

    pwl_sequencer #(
        .PAGE_W      (PAGE_W),
        .OFS_W       (OFS_W),
        .LOAD_WINDOW (LOAD_WINDOW),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_page (wr_addr[ADDR_W-1:OFS_W]),
        .accept  (accept),
        .busy    (busy),
        .load_err(load_err),
        .page_q  (page_q),
        .scan_act(scan_act),
        .scan_ofs(scan_ofs),
        .clr_mask(clr_mask)
    );

    pwl_page_buffer #(
        .OFS_W (OFS_W),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (accept),
        .ld_ofs  (wr_addr[OFS_W-1:0]),
        .ld_data (wr_data),
        .clr_mask(clr_mask),
        .rd_ofs  (scan_ofs),
        .rd_valid(slot_valid),
        .rd_data (slot_data)
    );

    pwl_last_byte #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept),
        .in_addr  (wr_addr),
        .in_data  (wr_data),
        .last_addr(last_addr),
        .last_data(last_data)
    );

    // Array write port: one strobe per staged offset during the scan.
    always_comb begin
        arr_we    = scan_act && slot_valid;
        arr_addr  = {page_q, scan_ofs};
        arr_wdata = slot_data;
    end

    // Host read path passes straight through to the array.
    assign arr_raddr = rd_addr;
    assign rd_data   = arr_rdata;
endmodule

// File: rtl/pwl_load_ctrl_chk.sv
// Property checker for pwl_load_ctrl, attached with bind below.
// Keeps its own counter of busy cycles so the period length is checked
// without a deep $past.
module pwl_load_ctrl_chk #(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 6,
    parameter int WRITE_CYCLES = 2500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic              load_err,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    int unsigned busy_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R5

    AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) && $past(rst_n) |->
        arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W])); // R1

    AST_OFS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) && $past(rst_n) |->
        arr_addr[OFS_W-1:0] > $past(arr_addr[OFS_W-1:0])); // R5

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> busy_run == WRITE_CYCLES); // R6

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < WRITE_CYCLES); // R6

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> $stable(last_addr) && $stable(last_data)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err); // R4
endmodule

bind pwl_load_ctrl pwl_load_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .OFS_W       (OFS_W),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (busy),
    .load_err (load_err),
    .last_addr(last_addr),
    .last_data(last_data),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/sim_pwl_load_ctrl.sv
// Bench: a behavioural reference model is compared on every cycle, and
// directed scenarios read the array back with values worked out by hand.
module sim_pwl_load_ctrl;
    localparam int LW = 20;
    localparam int WC = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [14:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, load_err;
    logic [14:0] last_addr;
    logic [7:0]  last_data;
    logic        arr_we;
    logic [14:0] arr_addr, arr_raddr;
    logic [7:0]  arr_wdata;
    logic [7:0]  arr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    pwl_load_ctrl #(.LOAD_WINDOW(LW), .WRITE_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .load_err(load_err), .last_addr(last_addr),
        .last_data(last_data), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
    );

    // Behavioural backing array, with a fixed pattern where never written.
    logic [7:0] mem [int];
    int mem_ver = 0;

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_get(input logic [14:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (arr_we) begin
            mem[int'(arr_addr)] = arr_wdata;
            mem_ver = mem_ver + 1;
        end
    end

    always @(arr_raddr or mem_ver) arr_rdata = mem_get(arr_raddr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model state: 0 idle, 1 loading, 2 programming.
    int         m_state = 0;
    int         m_gap = 0;
    int         m_prog = 0;
    int         m_page = 0;
    bit [63:0]  m_mask = '0;
    bit [7:0]   m_buf [64];
    bit         m_err = 1'b0;
    bit [14:0]  m_laddr = '0;
    bit [7:0]   m_ldata = '0;

    always @(posedge clk) begin
        cyc++;
        started = 1'b1;
        if (!rst_n) begin
            m_state = 0; m_gap = 0; m_prog = 0; m_mask = '0;
            m_err = 1'b0; m_laddr = '0; m_ldata = '0;
        end else begin
            case (m_state)
                0: if (wr_en) begin
                    m_page = int'(wr_addr[14:6]);
                    m_buf[wr_addr[5:0]] = wr_data;
                    m_mask[wr_addr[5:0]] = 1'b1;
                    m_laddr = wr_addr; m_ldata = wr_data;
                    m_gap = 0; m_state = 1;
                end
                1: begin
                    if (wr_en && int'(wr_addr[14:6]) == m_page) begin
                        m_buf[wr_addr[5:0]] = wr_data;
                        m_mask[wr_addr[5:0]] = 1'b1;
                        m_laddr = wr_addr; m_ldata = wr_data;
                        m_gap = 0;
                    end else begin
                        if (wr_en) m_err = 1'b1;
                        if (m_gap == LW - 1) begin
                            m_state = 2; m_prog = 0;
                        end else m_gap++;
                    end
                end
                default: begin
                    if (m_prog == WC - 1) begin
                        m_state = 0; m_mask = '0;
                    end else m_prog++;
                end
            endcase
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            bit        e_we;
            bit [14:0] e_addr;
            e_we = (m_state == 2) && (m_prog < 64) && m_mask[m_prog];
            e_addr = {m_page[8:0], m_prog[5:0]};
            check(busy == (m_state == 2), "R6", "busy", busy, m_state == 2);
            check(load_err == m_err, "R4", "load_err", load_err, m_err);
            check(last_addr == m_laddr, "R9", "last_addr", last_addr, m_laddr);
            check(last_data == m_ldata, "R9", "last_data", last_data, m_ldata);
            check(arr_we == e_we, "R5", "arr_we", arr_we, e_we);
            if (e_we) begin
                check(arr_addr == e_addr, "R1", "arr_addr", arr_addr, e_addr);
                check(arr_wdata == m_buf[m_prog], "R2", "arr_wdata",
                      arr_wdata, m_buf[m_prog]);
            end
            check(rd_data == mem_get(rd_addr), "R10", "rd_data",
                  rd_data, mem_get(rd_addr));
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic wr(input int page, input int ofs, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = {page[8:0], ofs[5:0]}; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input int page, input int ofs, input logic [7:0] e,
                             input string req);
        @(negedge clk); #1;
        rd_addr = {page[8:0], ofs[5:0]};
        @(negedge clk);
        check(rd_data == e, req, "array byte", rd_data, e);
    endtask

    // Gap from the last accepted byte to busy, then the busy length.
    task automatic time_session(input bit do_check);
        int n;
        n = 0;
        while (!busy) begin @(negedge clk); n++; end
        if (do_check) check(n == LW, "R3", "gap to busy", n, LW);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        if (do_check) check(n == WC, "R6", "busy length", n, WC);
    endtask

    task automatic do_reset();
        @(negedge clk); #1; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(busy == 1'b0, "R8", "busy after reset", busy, 0);
        check(load_err == 1'b0, "R8", "err after reset", load_err, 0);
        check(last_addr == 15'd0, "R8", "last_addr after reset", last_addr, 0);

        // Session A, page 3: out of order, with a reload of offset 5 (R2).
        wr(3, 5, 8'h11); wr(3, 0, 8'h22); wr(3, 63, 8'h33); wr(3, 5, 8'h44);
        check(last_addr == {9'd3, 6'd5}, "R9", "last_addr A", last_addr,
              {9'd3, 6'd5});
        time_session(1'b1);
        rd_expect(3, 0, 8'h22, "R1");
        rd_expect(3, 5, 8'h44, "R2");
        rd_expect(3, 63, 8'h33, "R2");
        rd_expect(3, 1, pat({9'd3, 6'd1}), "R5");
        rd_expect(3, 62, pat({9'd3, 6'd62}), "R5");

        // Session B, page 7: a wrong-page byte is dropped and sets the flag (R4).
        wr(7, 10, 8'h5C); wr(8, 10, 8'hEE);
        check(load_err == 1'b1, "R4", "err set", load_err, 1);
        while (!busy) @(negedge clk);
        // R6: a request during programming is ignored.
        wr(7, 11, 8'h99);
        check(last_addr == {9'd7, 6'd10}, "R6", "last_addr in busy", last_addr,
              {9'd7, 6'd10});
        while (busy) @(negedge clk);
        rd_expect(7, 10, 8'h5C, "R4");
        rd_expect(8, 10, pat({9'd8, 6'd10}), "R4");
        rd_expect(7, 11, pat({9'd7, 6'd11}), "R6");
        rd_expect(7, 0, pat({9'd7, 6'd0}), "R7");
        rd_expect(7, 5, pat({9'd7, 6'd5}), "R7");

        // Session C, page 20: a full page loaded in descending order (R2).
        for (int i = 63; i >= 0; i--) wr(20, i, 8'(i + 8'h80));
        time_session(1'b1);
        for (int i = 0; i < 64; i++) rd_expect(20, i, 8'(i + 8'h80), "R2");
        check(load_err == 1'b1, "R4", "err sticky", load_err, 1);

        // Reset in the middle of a session: nothing is committed (R8).
        wr(30, 1, 8'hAB);
        do_reset();
        check(load_err == 1'b0, "R8", "err cleared", load_err, 0);
        repeat (LW + WC + 5) @(negedge clk);
        check(busy == 1'b0, "R8", "no programming after reset", busy, 0);
        rd_expect(30, 1, pat({9'd30, 6'd1}), "R8");
        rd_expect(3, 0, 8'h22, "R8");

        // Session D, page 9: one byte; stale offsets must not leak (R7).
        wr(9, 40, 8'h6D);
        time_session(1'b1);
        rd_expect(9, 40, 8'h6D, "R7");
        rd_expect(9, 0, pat({9'd9, 6'd0}), "R7");
        rd_expect(9, 63, pat({9'd9, 6'd63}), "R7");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule